// File: doc/BRIEF.md
# PTP Timestamp Snapshot Lock Unit

This block serves one precision-time channel. It watches two streams of detected event messages, one for the receive side and one for the transmit side. When a qualifying message shows up, it copies the free-running 64-bit system time into that side's snapshot register. In normal operation it then raises a per-side lock flag. While the flag is up, the snapshot is frozen, so software can read an undisturbed timestamp at its own pace.

Which message type qualifies depends on the channel's role, which comes in on `master_mode`. A clock master timestamps outgoing Sync and incoming Delay_Req messages. A slave timestamps incoming Sync and outgoing Delay_Req messages. When the `ts_all` control input is high, the lock is bypassed: every qualifying message overwrites the snapshot and the flags are left alone.

Software uses a small word-addressed register port. It reads the two snapshots as low and high words and reads the flag register. It writes ones into the flag register to release a lock.

Top module: `ptp_snap_lock`

## Requirements
- R1: Receive capture triggers on message type 1 (Delay_Req) when `master_mode`=1, and on type 0 (Sync) when `master_mode`=0. Any other type, or an event without `rx_evt_valid`, captures nothing.
- R2: Transmit capture triggers on type 0 (Sync) when `master_mode`=1, and on type 1 (Delay_Req) when `master_mode`=0. Any other type, or an event without `tx_evt_valid`, captures nothing.
- R3: With `ts_all`=0, a qualifying event on an unlocked side stores `sys_time` from that clock edge into the side's snapshot and sets its lock flag.
- R4: With `ts_all`=0, while a side's lock flag is set, further qualifying events leave its snapshot unchanged.
- R5: A write to address 0 clears the transmit flag when `reg_wdata[0]`=1 and the receive flag when `reg_wdata[1]`=1. A 0 in either bit leaves that flag as it was.
- R6: After reset, both snapshots and both flags are 0.
- R7: Address 0 reads the transmit flag in bit 0 and the receive flag in bit 1, with bits 31:2 reading 0.
- R8: With `ts_all`=1, every qualifying event overwrites the snapshot with `sys_time`, and the lock flag is not set by the event.
- R9: If a clear and a qualifying event on the same side share a cycle while `ts_all`=0, the snapshot takes the new `sys_time` and the flag stays set.
- R10: The receive and transmit sides are independent: events on both in one cycle are both captured.
- R11: The read map is: address 1 receive low word, 2 receive high word, 3 transmit low word, 4 transmit high word. Addresses 5 to 7 read 0, and writes to any address other than 0 change nothing.
- R12: `reg_rdata` is registered. It shows the word selected by `reg_addr` at a clock edge, with the state from before that edge's updates, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = channel acts as clock master, 0 = slave |
| ts_all | input | 1 | 1 = capture every qualifying event, no locking |
| sys_time | input | 64 | Running system time value |
| rx_evt_valid | input | 1 | A receive message was detected this cycle |
| rx_evt_type | input | 2 | Receive message type: 0 Sync, 1 Delay_Req, others not timestamped |
| tx_evt_valid | input | 1 | A transmit message was detected this cycle |
| tx_evt_type | input | 2 | Transmit message type, same encoding |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 2 | Write data for the flag register, 1 bits clear flags |
| reg_rdata | output | 32 | Registered read data |

## Verification
A lock flag stuck in the wrong state shows at the ports in two ways. It shows directly in the flag word on the next read. It also shows one event later, as a snapshot that either moved when it should have stayed frozen or stayed frozen when it should have moved. A capture that takes the wrong edge's time, or goes to the wrong side, shows in the snapshot words read one cycle after that edge. Because the bench may read any address in every cycle, a divergence in either snapshot or either flag is reported on the first read of that word after the faulty edge. Role swaps, `ts_all` toggles and clears that collide with events are mixed in so that each path to the flags gets exercised.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned TYPE_W = 2;
  localparam int unsigned NSIDE  = 2;

  // side index doubles as the bit position in the flag register
  localparam int unsigned SIDE_TX = 0;
  localparam int unsigned SIDE_RX = 1;

  localparam logic [TYPE_W-1:0] MSG_SYNC      = 2'd0;
  localparam logic [TYPE_W-1:0] MSG_DELAY_REQ = 2'd1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FLAGS = 3'd0,
    ADR_RX_LO = 3'd1,
    ADR_RX_HI = 3'd2,
    ADR_TX_LO = 3'd3,
    ADR_TX_HI = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ptp_snap_trigger.sv
module ptp_snap_trigger
  import ptp_snap_pkg::*;
(
  input  logic              master_mode,
  input  logic              rx_valid,
  input  logic [TYPE_W-1:0] rx_type,
  input  logic              tx_valid,
  input  logic [TYPE_W-1:0] tx_type,
  output logic [NSIDE-1:0]  cap
);
  logic [TYPE_W-1:0] rx_want;
  logic [TYPE_W-1:0] tx_want;

  // master: stamp incoming Delay_Req and outgoing Sync; slave: the reverse
  always_comb begin
    rx_want = master_mode ? MSG_DELAY_REQ : MSG_SYNC;
    tx_want = master_mode ? MSG_SYNC      : MSG_DELAY_REQ;
    cap[SIDE_RX] = rx_valid && (rx_type == rx_want);
    cap[SIDE_TX] = tx_valid && (tx_type == tx_want);
  end
endmodule

// File: rtl/ptp_snap_slot.sv
module ptp_snap_slot #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ts_all,
  input  logic              cap,
  input  logic              clr,
  input  logic [TIME_W-1:0] sys_time,
  output logic [TIME_W-1:0] snap,
  output logic              flag
);
  logic load;

  // a clear in the same cycle releases the lock for this event
  assign load = cap && (ts_all || !flag || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
      flag <= 1'b0;
    end else begin
      if (load) snap <= sys_time;
      if (cap && !ts_all) flag <= 1'b1;
      else if (clr)       flag <= 1'b0;
    end
  end

  // R3
  property p_cap_sets;
    @(posedge clk) disable iff (rst) (cap && !ts_all) |=> flag;
  endproperty
  cap_sets_flag_chk: assert property (p_cap_sets);

  // R3
  property p_cap_value;
    @(posedge clk) disable iff (rst) (cap && !flag) |=> (snap == $past(sys_time));
  endproperty
  cap_value_chk: assert property (p_cap_value);

  // R4
  property p_locked;
    @(posedge clk) disable iff (rst) (flag && !clr && !ts_all) |=> $stable(snap);
  endproperty
  locked_hold_chk: assert property (p_locked);

  // R5
  property p_clear;
    @(posedge clk) disable iff (rst) (clr && !cap) |=> !flag;
  endproperty
  clear_flag_chk: assert property (p_clear);

  // R8
  property p_ts_all_flag;
    @(posedge clk) disable iff (rst) (ts_all && !clr) |=> $stable(flag);
  endproperty
  ts_all_flag_chk: assert property (p_ts_all_flag);

  // R8
  property p_ts_all_load;
    @(posedge clk) disable iff (rst) (ts_all && cap) |=> (snap == $past(sys_time));
  endproperty
  ts_all_load_chk: assert property (p_ts_all_load);
endmodule

// File: rtl/ptp_snap_regif.sv
module ptp_snap_regif
  import ptp_snap_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned REG_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NSIDE-1:0]             wdata,
  input  logic [NSIDE-1:0][TIME_W-1:0] snap,
  input  logic [NSIDE-1:0]             flag,
  output logic [NSIDE-1:0]             clr,
  output logic [REG_W-1:0]             rdata
);
  localparam int unsigned HI_W = TIME_W - REG_W;

  logic [REG_W-1:0] rd_next;

  assign clr = (wr && addr == ADR_FLAGS) ? wdata : '0;

  always_comb begin
    rd_next = '0;
    case (addr)
      ADR_FLAGS: rd_next[NSIDE-1:0] = flag;
      ADR_RX_LO: rd_next = snap[SIDE_RX][REG_W-1:0];
      ADR_RX_HI: rd_next[HI_W-1:0] = snap[SIDE_RX][TIME_W-1:REG_W];
      ADR_TX_LO: rd_next = snap[SIDE_TX][REG_W-1:0];
      ADR_TX_HI: rd_next[HI_W-1:0] = snap[SIDE_TX][TIME_W-1:REG_W];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R7
  property p_reserved;
    @(posedge clk) disable iff (rst) (addr == ADR_FLAGS) |=> (rdata[REG_W-1:NSIDE] == '0);
  endproperty
  reserved_zero_chk: assert property (p_reserved);

  // R11
  property p_unmapped;
    @(posedge clk) disable iff (rst) (addr > ADR_TX_HI) |=> (rdata == '0);
  endproperty
  unmapped_zero_chk: assert property (p_unmapped);

  // R5
  property p_clr_only_flags;
    @(posedge clk) disable iff (rst) (addr != ADR_FLAGS) |-> (clr == '0);
  endproperty
  clr_addr_chk: assert property (p_clr_only_flags);
endmodule

// File: rtl/ptp_snap_lock.sv
module ptp_snap_lock
  import ptp_snap_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              ts_all,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              rx_evt_valid,
  input  logic [TYPE_W-1:0] rx_evt_type,
  input  logic              tx_evt_valid,
  input  logic [TYPE_W-1:0] tx_evt_type,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSIDE-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [NSIDE-1:0]             cap;
  logic [NSIDE-1:0]             clr;
  logic [NSIDE-1:0]             flag;
  logic [NSIDE-1:0][TIME_W-1:0] snap;

  ptp_snap_trigger u_trig (
    .master_mode (master_mode),
    .rx_valid    (rx_evt_valid),
    .rx_type     (rx_evt_type),
    .tx_valid    (tx_evt_valid),
    .tx_type     (tx_evt_type),
    .cap         (cap)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    ptp_snap_slot #(.TIME_W(TIME_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .ts_all   (ts_all),
      .cap      (cap[s]),
      .clr      (clr[s]),
      .sys_time (sys_time),
      .snap     (snap[s]),
      .flag     (flag[s])
    );
  end

  ptp_snap_regif #(.TIME_W(TIME_W), .REG_W(REG_W)) u_regif (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .snap  (snap),
    .flag  (flag),
    .clr   (clr),
    .rdata (reg_rdata)
  );

  // R1
  property p_rx_trigger;
    @(posedge clk) disable iff (rst) cap[SIDE_RX] |-> (rx_evt_valid && rx_evt_type[1] == 1'b0);
  endproperty
  rx_trigger_chk: assert property (p_rx_trigger);

  // R2
  property p_tx_trigger;
    @(posedge clk) disable iff (rst) cap[SIDE_TX] |-> (tx_evt_valid && tx_evt_type[1] == 1'b0);
  endproperty
  tx_trigger_chk: assert property (p_tx_trigger);
endmodule

// File: tb/tb_ptp_snap_lock.sv
`timescale 1ns/1ps
module tb_ptp_snap_lock;
  logic        clk = 1'b0;
  logic        rst;
  logic        master_mode, ts_all;
  logic [63:0] sys_time;
  logic        rx_evt_valid, tx_evt_valid;
  logic [1:0]  rx_evt_type, tx_evt_type;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [1:0]  reg_wdata;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  // model state, index 0 = transmit, 1 = receive
  logic [63:0] m_snap [2];
  logic        m_flag [2];

  always #2.5 clk = ~clk;

  ptp_snap_lock dut (
    .clk(clk), .rst(rst), .master_mode(master_mode), .ts_all(ts_all),
    .sys_time(sys_time), .rx_evt_valid(rx_evt_valid), .rx_evt_type(rx_evt_type),
    .tx_evt_valid(tx_evt_valid), .tx_evt_type(tx_evt_type), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: exp_read = {30'd0, m_flag[1], m_flag[0]};
      3'd1: exp_read = m_snap[1][31:0];
      3'd2: exp_read = m_snap[1][63:32];
      3'd3: exp_read = m_snap[0][31:0];
      3'd4: exp_read = m_snap[0][63:32];
      default: exp_read = 32'd0;
    endcase
  endfunction

  function automatic logic qual(input logic m, input logic is_rx, input logic v, input logic [1:0] t);
    logic [1:0] want;
    want = (m ^ is_rx) ? 2'd0 : 2'd1;
    qual = v && (t == want);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic ta, input logic rv, input logic [1:0] rt,
                      input logic tv, input logic [1:0] tt, input logic wr,
                      input logic [2:0] a, input logic [1:0] wd, input logic [63:0] t,
                      input string tag);
    logic [31:0] e;
    logic        cp [2];
    logic        cl [2];
    @(negedge clk);
    master_mode = m; ts_all = ta; rx_evt_valid = rv; rx_evt_type = rt;
    tx_evt_valid = tv; tx_evt_type = tt; reg_wr = wr; reg_addr = a;
    reg_wdata = wd; sys_time = t;
    e = exp_read(a);
    @(posedge clk);
    cp[0] = qual(m, 1'b0, tv, tt);
    cp[1] = qual(m, 1'b1, rv, rt);
    for (int s = 0; s < 2; s++) begin
      cl[s] = wr && (a == 3'd0) && wd[s];
      if (cp[s] && (ta || !m_flag[s] || cl[s])) m_snap[s] = t;
      if (cp[s] && !ta) m_flag[s] = 1'b1;
      else if (cl[s])   m_flag[s] = 1'b0;
    end
    #1;
    check(reg_rdata, e, tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(master_mode, ts_all, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, a, 2'd0, 64'd0, tag);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 8; a++) rd(3'(a), tag);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; master_mode = 1'b1; ts_all = 1'b0; sys_time = '0;
    rx_evt_valid = 0; rx_evt_type = 0; tx_evt_valid = 0; tx_evt_type = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    for (int s = 0; s < 2; s++) begin m_snap[s] = '0; m_flag[s] = 1'b0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R6 and R11: everything reads zero after reset, unmapped included
    read_all("R6 reset");

    // R1: master ignores received Sync and other types
    step(1, 0, 1, 2'd0, 0, 0, 0, 3'd0, 0, 64'h1111_2222_3333_4444, "R1 master rx sync");
    step(1, 0, 1, 2'd3, 0, 0, 0, 3'd0, 0, 64'h1111_2222_3333_5555, "R1 master rx type3");
    rd(3'd0, "R1 no flag");
    // R1/R3: received Delay_Req in master captures
    step(1, 0, 1, 2'd1, 0, 0, 0, 3'd0, 0, 64'hA5A5_0001_DEAD_BEEF, "R3 capture rx");
    rd(3'd1, "R3 rx lo"); rd(3'd2, "R3 rx hi"); rd(3'd0, "R7 flags");
    // R4: locked
    step(1, 0, 1, 2'd1, 0, 0, 0, 3'd0, 0, 64'h0BAD_0BAD_0BAD_0BAD, "R4 locked rx");
    rd(3'd1, "R4 rx lo"); rd(3'd2, "R4 rx hi");
    // R5: write zero no effect, write one clears
    step(1, 0, 0, 0, 0, 0, 1, 3'd0, 2'b00, 64'd0, "R5 write0");
    rd(3'd0, "R5 still set");
    step(1, 0, 0, 0, 0, 0, 1, 3'd0, 2'b10, 64'd0, "R5 clear rx");
    rd(3'd0, "R5 cleared");
    // R2: slave transmits
    step(0, 0, 0, 0, 1, 2'd0, 0, 3'd0, 0, 64'h7777_0000_0000_0001, "R2 slave tx sync");
    step(0, 0, 0, 0, 1, 2'd1, 0, 3'd0, 0, 64'h7777_0000_0000_0002, "R2 slave tx dreq");
    rd(3'd3, "R2 tx lo"); rd(3'd4, "R2 tx hi"); rd(3'd0, "R2 flags");
    // R10: both sides together in slave mode
    step(0, 0, 0, 0, 0, 0, 1, 3'd0, 2'b11, 64'd0, "R10 clear both");
    step(0, 0, 1, 2'd0, 1, 2'd1, 0, 3'd0, 0, 64'hCAFE_F00D_1234_5678, "R10 both");
    read_all("R10 readback");
    // R9: clear and event collide
    step(0, 0, 1, 2'd0, 0, 0, 1, 3'd0, 2'b10, 64'h9999_8888_7777_6666, "R9 collide");
    rd(3'd0, "R9 flag stays"); rd(3'd1, "R9 rx lo"); rd(3'd2, "R9 rx hi");
    // R8: timestamp-all mode overwrites, flags untouched
    step(1, 1, 0, 0, 0, 0, 1, 3'd0, 2'b11, 64'd0, "R8 clear");
    step(1, 1, 1, 2'd1, 1, 2'd0, 0, 3'd0, 0, 64'h0000_0001_0000_0001, "R8 ev1");
    step(1, 1, 1, 2'd1, 1, 2'd0, 0, 3'd0, 0, 64'h0000_0002_0000_0002, "R8 ev2");
    read_all("R8 readback");
    // R11: write to other address ignored
    step(1, 0, 1, 2'd1, 0, 0, 0, 3'd0, 0, 64'h4242_4242_4242_4242, "R11 set rx");
    step(1, 0, 0, 0, 0, 0, 1, 3'd1, 2'b11, 64'd0, "R11 write addr1");
    rd(3'd0, "R11 flags kept");

    // random mix, R12 read timing checked every cycle
    for (int i = 0; i < 6000; i++) begin
      step($urandom_range(0, 7) == 0 ? ~master_mode : master_mode,
           $urandom_range(0, 9) == 0,
           1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
           $urandom_range(0, 5) == 0, 3'($urandom), 2'($urandom),
           {32'($urandom), 32'($urandom)}, "R12 random");
    end
    done = 1;
    finish_run();
  end
endmodule